// File: doc/BRIEF.md
# Inversion-counting merge sorter for rank-correlation numerators

This block takes a list of rank pairs, each packed into one 32-bit word with the u rank in bits 31:16 and the v rank in bits 15:0, and works out the numerator of a tie-adjusted rank correlation coefficient for the two rank vectors. The list must already be ordered by u first and by v second. The block reorders it by v with bottom-up merge passes that ping-pong between two single-read, single-write buffers. While it merges, it counts the pairs whose v order disagrees with their u order. Linear scans before and after the merge passes measure the tie groups in u, in v and in (u,v) jointly. These tie counts are then combined with the discordant count into the signed numerator.

A host writes the words into the primary buffer through a load port while the block is idle. It then pulses `start` with the element count. When `done` rises, the host reads `disc_cnt` and `numer`. It can also read the v-sorted list back from the primary buffer through the read port. The final normalisation by a square root is left to the host.

Top module: `ktau_merge_counter`

## Requirements
- R1: While idle, a cycle with `ld_we` high writes `ld_data` into primary buffer entry `ld_addr`. Each word holds u in bits 31:16 and v in bits 15:0. A job over `len` words (0 to MAX_N) starts on a `start` pulse taken while `busy` is low.
- R2: After `done`, reading entry k (k < len) through `rd_addr` returns the k-th smallest v value in bits 15:0, with bits 31:16 cleared.
- R3: `disc_cnt` equals the number of index pairs i < j in the loaded list with v[j] strictly less than v[i]. Pairs with equal v are not counted.
- R4: `numer` (signed) equals n0 − T1 − T2 + T3 − 2·`disc_cnt`. Here n0 = len·(len−1)/2, and T1, T2 and T3 are the sums of t(t−1)/2 over the groups of equal u, of equal v and of equal (u,v). This equals the concordant count minus the discordant count.
- R5: A `start` pulse while `busy` is high is ignored. The running job keeps its length and its results.
- R6: A job with len 0 or 1 completes with `disc_cnt` = 0 and `numer` = 0. With len 1, the single entry is returned with its upper half cleared.
- R7: Lengths that are not a power of two are handled: the last run of each pass is clipped to the list end, and the results follow R2 to R4.
- R8: `busy` is high from the cycle after an accepted `start` until `done` rises, and `busy` and `done` are never high together. `done` stays high, with `disc_cnt` and `numer` unchanged, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Load strobe for the primary buffer (idle only) |
| ld_addr | input | AW | Load address |
| ld_data | input | 32 | Packed word, u in 31:16, v in 15:0 |
| start | input | 1 | Job start pulse |
| len | input | CW | Element count of the job |
| busy | output | 1 | Job in progress |
| done | output | 1 | Results valid and held |
| rd_addr | input | AW | Read-back address into the primary buffer |
| rd_data | output | 32 | Read-back word (combinational) |
| disc_cnt | output | 2·CW | Discordant pair count |
| numer | output | 2·CW+1 | Signed numerator, concordant minus discordant |

## Verification
The bench builds the block with MAX_N = 16. That makes both a full-depth job (a 16-entry reversed list with 120 discordant pairs) and odd lengths such as 5, 7 and 11 short enough to run. These lengths exercise clipped final runs and a result that lands in the secondary buffer and has to be copied back. Small lists with heavy u, v and joint ties exercise every tie term of the numerator. The zero- and one-element lengths reach the paths that skip every merge pass.

// File: rtl/ktau_pkg.sv
package ktau_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN1,
        ST_RUN,
        ST_LDL,
        ST_LDR,
        ST_MERGE,
        ST_PASS,
        ST_SCAN2
    } st_e;
endpackage

// File: rtl/ktau_mem.sv
module ktau_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ktau_tie_acc.sv
module ktau_tie_acc #(
    parameter int RW = 8,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic          eq,
    output logic [SW-1:0] sum
);
    logic [RW-1:0] run_d, run_q;
    logic [SW-1:0] sum_d, sum_q;

    // Each element equal to its predecessor pairs with every earlier member of its group.
    always_comb begin
        run_d = run_q;
        sum_d = sum_q;
        if (clr) begin
            run_d = '0;
            sum_d = '0;
        end else if (step) begin
            if (eq) begin
                sum_d = sum_q + SW'(run_q) + SW'(1);
                run_d = run_q + RW'(1);
            end else begin
                run_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            sum_q <= '0;
        end else begin
            run_q <= run_d;
            sum_q <= sum_d;
        end
    end

    assign sum = sum_q;
endmodule

// File: rtl/ktau_merge_counter.sv
module ktau_merge_counter
    import ktau_pkg::*;
#(
    parameter int MAX_N = 256,
    localparam int AW = (MAX_N > 1) ? $clog2(MAX_N) : 1,
    localparam int CW = $clog2(MAX_N + 1),
    localparam int SW = 2 * CW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_we,
    input  logic [AW-1:0]        ld_addr,
    input  logic [31:0]          ld_data,
    input  logic                 start,
    input  logic [CW-1:0]        len,
    output logic                 busy,
    output logic                 done,
    input  logic [AW-1:0]        rd_addr,
    output logic [31:0]          rd_data,
    output logic [SW-1:0]        disc_cnt,
    output logic signed [SW:0]   numer
);
    localparam int DW = 32;
    localparam int HW = 16;
    localparam int XW = CW + 2;

    typedef struct packed {
        st_e           st;
        logic          done;
        logic [CW-1:0] n;
        logic [XW-1:0] i;
        logic [XW-1:0] s;
        logic [XW-1:0] base;
        logic [XW-1:0] lp;
        logic [XW-1:0] rp;
        logic [XW-1:0] mid;
        logic [XW-1:0] rend;
        logic [XW-1:0] p;
        logic [HW-1:0] lh;
        logic [HW-1:0] rh;
        logic          lv;
        logic          rv;
        logic          src_b;
        logic [DW-1:0] prev;
        logic [SW-1:0] nd;
    } reg_t;

    reg_t q, d;

    logic          a_we, b_we;
    logic [AW-1:0] a_wa, b_wa, a_ra, b_ra;
    logic [DW-1:0] a_wd, b_wd, a_rd, b_rd;
    logic [HW-1:0] in_v;
    logic          clr, step1, step2, eq_u, eq_j, eq_v;
    logic [SW-1:0] t1, t2, t3;
    logic [XW-1:0] n_x, sum_mid, sum_end, nxt_base;
    logic [DW-1:0] word;
    logic          take_r;
    logic [CW-1:0] n_cur;

    ktau_mem #(.DW(DW), .DEPTH(MAX_N), .AW(AW)) u_buf_a (
        .clk(clk), .we(a_we), .waddr(a_wa), .wdata(a_wd), .raddr(a_ra), .rdata(a_rd)
    );
    ktau_mem #(.DW(DW), .DEPTH(MAX_N), .AW(AW)) u_buf_b (
        .clk(clk), .we(b_we), .waddr(b_wa), .wdata(b_wd), .raddr(b_ra), .rdata(b_rd)
    );

    ktau_tie_acc #(.RW(CW), .SW(SW)) u_tie_u (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(step1), .eq(eq_u), .sum(t1)
    );
    ktau_tie_acc #(.RW(CW), .SW(SW)) u_tie_v (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(step2), .eq(eq_v), .sum(t2)
    );
    ktau_tie_acc #(.RW(CW), .SW(SW)) u_tie_j (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(step1), .eq(eq_j), .sum(t3)
    );

    assign n_x      = XW'(q.n);
    assign sum_mid  = q.base + q.s;
    assign sum_end  = q.base + (q.s << 1);
    assign nxt_base = sum_end;
    assign in_v     = q.src_b ? b_rd[HW-1:0] : a_rd[HW-1:0];

    always_comb begin
        d      = q;
        a_we   = 1'b0;
        a_wa   = '0;
        a_wd   = '0;
        a_ra   = rd_addr;
        b_we   = 1'b0;
        b_wa   = '0;
        b_wd   = '0;
        b_ra   = '0;
        clr    = 1'b0;
        step1  = 1'b0;
        step2  = 1'b0;
        eq_u   = 1'b0;
        eq_j   = 1'b0;
        eq_v   = 1'b0;
        word   = '0;
        take_r = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (ld_we) begin
                    a_we = 1'b1;
                    a_wa = ld_addr;
                    a_wd = ld_data;
                end
                if (start) begin
                    d.st    = ST_SCAN1;
                    d.done  = 1'b0;
                    d.n     = (len > CW'(MAX_N)) ? CW'(MAX_N) : len;
                    d.i     = '0;
                    d.nd    = '0;
                    d.src_b = 1'b0;
                    clr     = 1'b1;
                end
            end
            // u and joint tie scan; strips u so that the merges order by v alone
            ST_SCAN1: begin
                if (q.i < n_x) begin
                    a_ra   = q.i[AW-1:0];
                    word   = a_rd;
                    step1  = 1'b1;
                    eq_u   = (q.i != '0) && (word[DW-1:HW] == q.prev[DW-1:HW]);
                    eq_j   = (q.i != '0) && (word == q.prev);
                    a_we   = 1'b1;
                    a_wa   = q.i[AW-1:0];
                    a_wd   = {{HW{1'b0}}, word[HW-1:0]};
                    d.prev = word;
                    d.i    = q.i + XW'(1);
                end else begin
                    d.s    = XW'(1);
                    d.base = '0;
                    d.i    = '0;
                    d.st   = (q.n > CW'(1)) ? ST_RUN : ST_SCAN2;
                end
            end
            ST_RUN: begin
                d.mid  = (sum_mid < n_x) ? sum_mid : n_x;
                d.rend = (sum_end < n_x) ? sum_end : n_x;
                d.lp   = q.base;
                d.rp   = (sum_mid < n_x) ? sum_mid : n_x;
                d.p    = q.base;
                d.st   = ST_LDL;
            end
            ST_LDL: begin
                if (q.src_b) b_ra = q.lp[AW-1:0];
                else         a_ra = q.lp[AW-1:0];
                d.lh = in_v;
                d.lv = 1'b1;
                d.lp = q.lp + XW'(1);
                d.st = ST_LDR;
            end
            ST_LDR: begin
                if (q.rp < q.rend) begin
                    if (q.src_b) b_ra = q.rp[AW-1:0];
                    else         a_ra = q.rp[AW-1:0];
                    d.rh = in_v;
                    d.rv = 1'b1;
                    d.rp = q.rp + XW'(1);
                end else begin
                    d.rv = 1'b0;
                end
                d.st = ST_MERGE;
            end
            ST_MERGE: begin
                if (q.lv || q.rv) begin
                    take_r = q.rv && (!q.lv || (q.rh < q.lh));
                    if (q.src_b) begin
                        a_we = 1'b1;
                        a_wa = q.p[AW-1:0];
                        a_wd = {{HW{1'b0}}, take_r ? q.rh : q.lh};
                    end else begin
                        b_we = 1'b1;
                        b_wa = q.p[AW-1:0];
                        b_wd = {{HW{1'b0}}, take_r ? q.rh : q.lh};
                    end
                    d.p = q.p + XW'(1);
                    if (take_r) begin
                        // every left element still waiting (head included) outranks this one
                        if (q.lv) d.nd = q.nd + SW'(q.mid - q.lp + XW'(1));
                        if (q.rp < q.rend) begin
                            if (q.src_b) b_ra = q.rp[AW-1:0];
                            else         a_ra = q.rp[AW-1:0];
                            d.rh = in_v;
                            d.rp = q.rp + XW'(1);
                        end else begin
                            d.rv = 1'b0;
                        end
                    end else begin
                        if (q.lp < q.mid) begin
                            if (q.src_b) b_ra = q.lp[AW-1:0];
                            else         a_ra = q.lp[AW-1:0];
                            d.lh = in_v;
                            d.lp = q.lp + XW'(1);
                        end else begin
                            d.lv = 1'b0;
                        end
                    end
                end else begin
                    d.base = nxt_base;
                    d.st   = (nxt_base >= n_x) ? ST_PASS : ST_RUN;
                end
            end
            ST_PASS: begin
                d.s     = q.s << 1;
                d.src_b = !q.src_b;
                d.base  = '0;
                d.i     = '0;
                d.st    = ((q.s << 1) < n_x) ? ST_RUN : ST_SCAN2;
            end
            // v tie scan on the sorted list, copying it home if it sits in the secondary buffer
            ST_SCAN2: begin
                if (q.i < n_x) begin
                    if (q.src_b) begin
                        b_ra = q.i[AW-1:0];
                        word = b_rd;
                        a_we = 1'b1;
                        a_wa = q.i[AW-1:0];
                        a_wd = b_rd;
                    end else begin
                        a_ra = q.i[AW-1:0];
                        word = a_rd;
                    end
                    step2  = 1'b1;
                    eq_v   = (q.i != '0) && (word[HW-1:0] == q.prev[HW-1:0]);
                    d.prev = word;
                    d.i    = q.i + XW'(1);
                end else begin
                    d.src_b = 1'b0;
                    d.done  = 1'b1;
                    d.st    = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    logic [SW-1:0] pairs_all;
    logic [SW:0]   num_u;

    assign pairs_all = (SW'(q.n) * (SW'(q.n) - SW'(1))) >> 1;
    assign num_u     = {1'b0, pairs_all} - {1'b0, t1} - {1'b0, t2} + {1'b0, t3}
                       - {q.nd, 1'b0};
    assign numer     = $signed(num_u);
    assign disc_cnt  = q.nd;
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign rd_data   = a_rd;
    assign n_cur     = q.n;
endmodule

// File: rtl/ktau_merge_counter_chk.sv
module ktau_merge_counter_chk #(
    parameter int MAX_N = 256,
    localparam int CW = $clog2(MAX_N + 1),
    localparam int SW = 2 * CW
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [CW-1:0]       n_q,
    input logic [SW-1:0]       disc_cnt,
    input logic signed [SW:0]  numer
);
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R8

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(disc_cnt) && $stable(numer))); // R8

    AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R8

    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(n_q)); // R5

    AST_DISC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(disc_cnt) * 2 <= int'(n_q) * (int'(n_q) - 1))); // R3

    AST_NUMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((int'(numer) * 2 <= int'(n_q) * (int'(n_q) - 1)) &&
                  (int'(numer) * 2 >= -(int'(n_q) * (int'(n_q) - 1))))); // R4
endmodule

bind ktau_merge_counter ktau_merge_counter_chk #(.MAX_N(MAX_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .n_q(n_cur), .disc_cnt(disc_cnt), .numer(numer)
);

// File: tb/sim_ktau_merge_counter.sv
module sim_ktau_merge_counter;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_N = 16;
    localparam int AW = 4;
    localparam int CW = 5;
    localparam int SW = 10;
    localparam int NT = 6;

    localparam int TN [NT] = '{4, 4, 5, 7, 3, 6};
    localparam logic [31:0] TW [NT][8] = '{
        '{32'h00000000, 32'h00010001, 32'h00020002, 32'h00030003, 0, 0, 0, 0},
        '{32'h00000003, 32'h00010002, 32'h00020001, 32'h00030000, 0, 0, 0, 0},
        '{32'h00000002, 32'h00000004, 32'h00010001, 32'h00020001, 32'h00030000, 0, 0, 0},
        '{32'h00000005, 32'h00010005, 32'h00010006, 32'h00020000, 32'h00020000,
          32'h00030003, 32'h00040001, 0},
        '{32'h00000000, 32'h00000000, 32'h00000000, 0, 0, 0, 0, 0},
        '{32'h00000001, 32'h00010000, 32'h00020003, 32'h00030002, 32'h00040005,
          32'h00050004, 0, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic start = 1'b0;
    logic [CW-1:0] len = '0;
    logic busy, done;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [SW-1:0] disc_cnt;
    logic signed [SW:0] numer;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] wl [MAX_N];

    always #(CLK_PERIOD/2) clk = ~clk;

    ktau_merge_counter #(.MAX_N(MAX_N)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .start(start), .len(len), .busy(busy), .done(done), .rd_addr(rd_addr),
        .rd_data(rd_data), .disc_cnt(disc_cnt), .numer(numer)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sgn(input int x);
        return (x > 0) ? 1 : ((x < 0) ? -1 : 0);
    endfunction

    function automatic int ref_disc(input int n);
        int c = 0;
        for (int i = 0; i < n; i++)
            for (int j = i + 1; j < n; j++)
                if (int'(wl[j][15:0]) < int'(wl[i][15:0])) c++;
        return c;
    endfunction

    function automatic int ref_numer(input int n);
        int c = 0;
        for (int i = 0; i < n; i++)
            for (int j = i + 1; j < n; j++)
                c += sgn(int'(wl[i][31:16]) - int'(wl[j][31:16])) *
                     sgn(int'(wl[i][15:0]) - int'(wl[j][15:0]));
        return c;
    endfunction

    task automatic load_list(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ld_we = 1'b1;
            ld_addr = AW'(k);
            ld_data = wl[k];
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(done, "R8 done", done, 1);
    endtask

    task automatic run_job(input int n);
        @(negedge clk);
        start = 1'b1;
        len = CW'(n);
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R8 busy after start", busy, 1);
        wait_done();
    endtask

    task automatic check_results(input int n, input string tag);
        int sv [MAX_N];
        int tmp;
        check(int'(disc_cnt) == ref_disc(n), {tag, " R3 disc"}, disc_cnt, ref_disc(n));
        check(int'(numer) == ref_numer(n), {tag, " R4 numer"}, int'(numer), ref_numer(n));
        for (int k = 0; k < n; k++) sv[k] = int'(wl[k][15:0]);
        for (int a = 0; a < n; a++)
            for (int b = 0; b + 1 < n - a; b++)
                if (sv[b] > sv[b+1]) begin
                    tmp = sv[b]; sv[b] = sv[b+1]; sv[b+1] = tmp;
                end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rd_addr = AW'(k);
            #1;
            check(rd_data == 32'(sv[k]), {tag, " R2 sorted"}, rd_data, sv[k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R8 reset idle", {busy, done}, 0);
        check(disc_cnt == '0, "R3 reset count", disc_cnt, 0);

        // R1..R4 table of pre-sorted lists
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < 8; k++) wl[k] = TW[t][k];
            load_list(TN[t]);
            run_job(TN[t]);
            check_results(TN[t], $sformatf("R1 table%0d", t));
        end

        // R6 empty and single-element jobs
        run_job(0);
        check(disc_cnt == '0 && numer == '0, "R6 len0", int'(numer), 0);
        wl[0] = 32'h0007_0009;
        load_list(1);
        run_job(1);
        check(disc_cnt == '0 && numer == '0, "R6 len1", int'(numer), 0);
        @(negedge clk);
        rd_addr = '0;
        #1;
        check(rd_data == 32'h0000_0009, "R6 len1 word", rd_data, 32'h9);

        // R7 full depth reversed, then odd length
        for (int k = 0; k < 16; k++) wl[k] = {16'(k), 16'(15 - k)};
        load_list(16);
        run_job(16);
        check(disc_cnt == 10'd120, "R7 full reversed", disc_cnt, 120);
        check_results(16, "R7 n16");
        for (int k = 0; k < 11; k++) wl[k] = {16'(k), 16'((k * 7) % 11)};
        load_list(11);
        run_job(11);
        check_results(11, "R7 n11");

        // R8 results held after done
        repeat (4) @(negedge clk);
        check(done && disc_cnt == SW'(ref_disc(11)), "R8 hold", disc_cnt, ref_disc(11));

        // R5 start while busy is ignored
        for (int k = 0; k < 8; k++) wl[k] = TW[1][k];
        load_list(4);
        @(negedge clk);
        start = 1'b1;
        len = CW'(4);
        @(negedge clk);
        len = CW'(2);
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check(disc_cnt == 10'd6, "R5 start ignored", disc_cnt, 6);
        check_results(4, "R5");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule